// File: doc/BRIEF.md
# Descriptor-Chained XOR Copy Engine

A single-channel data mover that walks a linked list of descriptors held in memory. Each descriptor names a destination buffer, a byte count, a pointer to the next descriptor and up to eight source buffers. For every 32-bit word of the transfer, the engine reads each enabled source, combines the words by bitwise XOR and writes the result to the destination. In copy mode only the first source slot is used, so the engine acts as a plain memory copy.

Software loads a start pointer, sets the activation bit and polls a state field until the channel leaves the running state. After each descriptor the engine writes a completion word back into that descriptor and can raise an end-of-descriptor interrupt. To add work after a chain has finished, software links the new descriptor and activates the channel again from a fresh start pointer. All memory traffic uses one word-wide request port: the engine holds each request until the memory acknowledges it.

Descriptor layout, as word offsets from its base: 0 is the status word, 1 the command word, 2 the byte count, 3 the destination, 4 the next pointer, and 5+i source slot i.

Top module: `xor_desc_engine`

## Requirements
- R1: After reset the state field (register 2, bits [5:4]) reads 0, the current-descriptor register (register 3) reads 0, and irq_o and mem_req_o are low.
- R2: When configuration bits [2:0] are not 3'b010 (XOR mode), each destination word is the XOR of the matching words of the sources whose command bit i (bits [7:0]) is set. Sources whose bit is clear are never read. An empty mask writes zero.
- R3: When configuration bits [2:0] equal 3'b010 (copy mode), only source slot 0 is read and copied, whatever the command mask.
- R4: After a descriptor the engine follows the next pointer (word 4). A pointer of zero ends the chain, and the channel returns to idle.
- R5: After the data of a descriptor, the engine writes 32'h4000_0000 to its status word (word 0). Register 3 holds the address of the descriptor being processed or last processed, and it changes only on activation or on a step along the chain.
- R6: When command bit 31 is set, irq_o pulses for exactly one cycle, in the cycle after the status write completes. Without that bit it stays low.
- R7: A byte count that is not a multiple of 4, is below MIN_BYTES or is above MAX_BYTES makes no destination write. The engine writes 32'h0000_0001 to the status word, stops the chain and sets the state field to 2.
- R8: Writing 1 to bit 0 of register 2 starts the channel at the address in register 1 when the state field is not 1. While the state field is 1, the write is ignored.
- R9: With configuration bit 3 set, descriptor words are byte-reversed as they are read, and the status word is byte-reversed as it is written. Source and destination data are not reversed.
- R10: A memory request holds its address, direction and write data stable until mem_ack_i is seen.
- R11: The state field reads 1 while the channel runs, 0 when idle and 2 after an error halt. The value 3 never appears, and no memory request is issued unless the channel runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register select: 0 config, 1 next pointer, 2 activation/state, 3 current descriptor |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i |
| irq_o | output | 1 | End-of-descriptor interrupt pulse |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | AW | Byte address of the word |
| mem_wdata_o | output | 32 | Write data |
| mem_rdata_i | input | 32 | Read data, valid with mem_ack_i |
| mem_ack_i | input | 1 | Completes the pending request |

## Verification
The bench sweeps all 256 source masks and counts the reads that reach each source region. An engine that fetched disabled sources, or that mishandled the empty mask, would show extra reads or a non-zero result. Bad byte counts placed in the middle of a chain (unaligned, under the minimum, over the maximum) check that the engine halts exactly there. A wrong engine would write the destination or go on to the following descriptor. A second activation during a long transfer must leave the queued descriptor untouched until the channel is activated again from idle. The byte-reversed descriptor test catches an engine that reverses the data or leaves the status word unreversed.

// File: rtl/xor_eng_pkg.sv
package xor_eng_pkg;
  typedef enum logic [2:0] {F_IDLE, F_DLOAD, F_CHECK, F_SRC, F_WR, F_STAT} fsm_e;

  localparam logic [1:0] CH_IDLE = 2'd0;
  localparam logic [1:0] CH_RUN  = 2'd1;
  localparam logic [1:0] CH_HALT = 2'd2;

  localparam logic [1:0] REG_CFG  = 2'd0;
  localparam logic [1:0] REG_NEXT = 2'd1;
  localparam logic [1:0] REG_ACT  = 2'd2;
  localparam logic [1:0] REG_CUR  = 2'd3;

  localparam logic [2:0] MODE_COPY = 3'b010;

  // descriptor word offsets
  localparam int W_CMD  = 1;
  localparam int W_CNT  = 2;
  localparam int W_DST  = 3;
  localparam int W_NXT  = 4;
  localparam int W_SRC0 = 5;

  localparam int IRQ_BIT = 31;
  localparam logic [31:0] STAT_DONE = 32'h4000_0000;
  localparam logic [31:0] STAT_FAIL = 32'h0000_0001;

  function automatic logic [31:0] bswap32(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction
endpackage

// File: rtl/xor_eng_regs.sv
module xor_eng_regs
  import xor_eng_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic [1:0]    reg_addr_i,
  input  logic [31:0]   reg_wdata_i,
  input  logic [1:0]    chan_state_i,
  input  logic [AW-1:0] cur_desc_i,
  output logic [31:0]   reg_rdata_o,
  output logic [2:0]    mode_o,
  output logic          swap_o,
  output logic [AW-1:0] next_ptr_o,
  output logic          start_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_o     <= '0;
      swap_o     <= 1'b0;
      next_ptr_o <= '0;
    end else if (reg_we_i) begin
      case (reg_addr_i)
        REG_CFG: begin
          mode_o <= reg_wdata_i[2:0];
          swap_o <= reg_wdata_i[3];
        end
        REG_NEXT: next_ptr_o <= reg_wdata_i[AW-1:0];
        default: ;
      endcase
    end
  end

  // activation only honoured when the channel is not running
  assign start_o = reg_we_i && (reg_addr_i == REG_ACT) && reg_wdata_i[0]
                   && (chan_state_i != CH_RUN);

  always_comb begin
    case (reg_addr_i)
      REG_CFG:  reg_rdata_o = {28'd0, swap_o, mode_o};
      REG_NEXT: reg_rdata_o = 32'(next_ptr_o);
      REG_ACT:  reg_rdata_o = {26'd0, chan_state_i, 4'd0};
      default:  reg_rdata_o = 32'(cur_desc_i);
    endcase
  end
endmodule

// File: rtl/xor_eng_srcsel.sv
module xor_eng_srcsel #(
  parameter int NSRC = 8,
  parameter int SW   = $clog2(NSRC)
) (
  input  logic [NSRC-1:0] pend_i,
  output logic [NSRC-1:0] pick_o,
  output logic [SW-1:0]   idx_o
);
  logic [NSRC-1:0] below;

  // lowest pending source wins
  assign below[0]  = 1'b0;
  assign pick_o[0] = pend_i[0];
  for (genvar i = 1; i < NSRC; i++) begin : g_pri
    assign below[i]  = below[i-1] | pend_i[i-1];
    assign pick_o[i] = pend_i[i] & ~below[i];
  end

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (pick_o[i]) idx_o = idx_o | SW'(i);
    end
  end
endmodule

// File: rtl/xor_eng_ctrl.sv
module xor_eng_ctrl
  import xor_eng_pkg::*;
#(
  parameter int AW        = 32,
  parameter int NSRC      = 8,
  parameter int MIN_BYTES = 8,
  parameter int MAX_BYTES = 1024,
  parameter int SW        = $clog2(NSRC)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [AW-1:0]   next_ptr_i,
  input  logic [2:0]      mode_i,
  input  logic            swap_i,
  input  logic [NSRC-1:0] pick_i,
  input  logic [SW-1:0]   idx_i,
  output logic [NSRC-1:0] pend_o,
  output logic [1:0]      chan_state_o,
  output logic [AW-1:0]   cur_desc_o,
  output logic            irq_o,
  output logic            mem_req_o,
  output logic            mem_we_o,
  output logic [AW-1:0]   mem_addr_o,
  output logic [31:0]     mem_wdata_o,
  input  logic [31:0]     mem_rdata_i,
  input  logic            mem_ack_i
);
  localparam int NDW   = W_SRC0 + NSRC;
  localparam int LASTW = NDW - 1;
  localparam int FIW   = $clog2(NDW);
  localparam int MAXW  = MAX_BYTES / 4;
  localparam int WW    = $clog2(MAXW + 1);

  fsm_e            fsm_q;
  logic [1:0]      chan_q;
  logic [AW-1:0]   cur_q, dst_q, nxt_q;
  logic [AW-1:0]   src_q [NSRC];
  logic [FIW-1:0]  fidx_q, sofs;
  logic [NSRC-1:0] cmd_mask_q, mask_q, pend_q, mask_n, pend_n;
  logic            cmd_irq_q, err_q, irq_q, bad;
  logic [31:0]     cnt_q, acc_q, rdv, stat;
  logic [WW-1:0]   widx_q, nwords_q;

  assign rdv    = swap_i ? bswap32(mem_rdata_i) : mem_rdata_i;
  assign sofs   = fidx_q - FIW'(W_SRC0);
  assign mask_n = (mode_i == MODE_COPY) ? NSRC'(1) : cmd_mask_q;
  assign pend_n = pend_q & ~pick_i;
  assign bad    = (cnt_q[1:0] != 2'b00) || (cnt_q < 32'(MIN_BYTES))
                  || (cnt_q > 32'(MAX_BYTES));
  assign stat   = err_q ? STAT_FAIL : STAT_DONE;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fsm_q      <= F_IDLE;
      chan_q     <= CH_IDLE;
      cur_q      <= '0;
      dst_q      <= '0;
      nxt_q      <= '0;
      for (int i = 0; i < NSRC; i++) src_q[i] <= '0;
      fidx_q     <= '0;
      cmd_mask_q <= '0;
      cmd_irq_q  <= 1'b0;
      cnt_q      <= '0;
      err_q      <= 1'b0;
      mask_q     <= '0;
      pend_q     <= '0;
      acc_q      <= '0;
      widx_q     <= '0;
      nwords_q   <= '0;
      irq_q      <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      unique case (fsm_q)
        F_IDLE: if (start_i) begin
          cur_q  <= next_ptr_i;
          fidx_q <= FIW'(W_CMD);
          err_q  <= 1'b0;
          chan_q <= CH_RUN;
          fsm_q  <= F_DLOAD;
        end
        F_DLOAD: if (mem_ack_i) begin
          if (fidx_q == FIW'(W_CMD)) begin
            cmd_mask_q <= rdv[NSRC-1:0];
            cmd_irq_q  <= rdv[IRQ_BIT];
          end else if (fidx_q == FIW'(W_CNT)) cnt_q <= rdv;
          else if (fidx_q == FIW'(W_DST)) dst_q <= rdv[AW-1:0];
          else if (fidx_q == FIW'(W_NXT)) nxt_q <= rdv[AW-1:0];
          else src_q[sofs[SW-1:0]] <= rdv[AW-1:0];
          if (fidx_q == FIW'(LASTW)) fsm_q <= F_CHECK;
          else fidx_q <= fidx_q + FIW'(1);
        end
        F_CHECK: begin
          if (bad) begin
            err_q <= 1'b1;
            fsm_q <= F_STAT;
          end else begin
            nwords_q <= WW'(cnt_q >> 2);
            widx_q   <= '0;
            acc_q    <= '0;
            mask_q   <= mask_n;
            pend_q   <= mask_n;
            fsm_q    <= (mask_n == '0) ? F_WR : F_SRC;
          end
        end
        F_SRC: if (mem_ack_i) begin
          acc_q  <= acc_q ^ mem_rdata_i;
          pend_q <= pend_n;
          if (pend_n == '0) fsm_q <= F_WR;
        end
        F_WR: if (mem_ack_i) begin
          if (widx_q == nwords_q - WW'(1)) fsm_q <= F_STAT;
          else begin
            widx_q <= widx_q + WW'(1);
            acc_q  <= '0;
            pend_q <= mask_q;
            fsm_q  <= (mask_q == '0) ? F_WR : F_SRC;
          end
        end
        F_STAT: if (mem_ack_i) begin
          irq_q <= cmd_irq_q & ~err_q;
          if (err_q) begin
            chan_q <= CH_HALT;
            fsm_q  <= F_IDLE;
          end else if (nxt_q == '0) begin
            chan_q <= CH_IDLE;
            fsm_q  <= F_IDLE;
          end else begin
            cur_q  <= nxt_q;
            fidx_q <= FIW'(W_CMD);
            fsm_q  <= F_DLOAD;
          end
        end
        default: fsm_q <= F_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = '0;
    mem_wdata_o = '0;
    case (fsm_q)
      F_DLOAD: begin
        mem_req_o  = 1'b1;
        mem_addr_o = cur_q + (AW'(fidx_q) << 2);
      end
      F_SRC: begin
        mem_req_o  = 1'b1;
        mem_addr_o = src_q[idx_i] + (AW'(widx_q) << 2);
      end
      F_WR: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = dst_q + (AW'(widx_q) << 2);
        mem_wdata_o = acc_q;
      end
      F_STAT: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = cur_q;
        mem_wdata_o = swap_i ? bswap32(stat) : stat;
      end
      default: ;
    endcase
  end

  assign pend_o       = pend_q;
  assign chan_state_o = chan_q;
  assign cur_desc_o   = cur_q;
  assign irq_o        = irq_q;
endmodule

// File: rtl/xor_desc_engine.sv
module xor_desc_engine #(
  parameter int AW        = 32,
  parameter int NSRC      = 8,
  parameter int MIN_BYTES = 8,
  parameter int MAX_BYTES = 1024
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic [1:0]    reg_addr_i,
  input  logic [31:0]   reg_wdata_i,
  output logic [31:0]   reg_rdata_o,
  output logic          irq_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [31:0]   mem_wdata_o,
  input  logic [31:0]   mem_rdata_i,
  input  logic          mem_ack_i
);
  localparam int SW = $clog2(NSRC);

  logic [2:0]      mode;
  logic            swap, start;
  logic [AW-1:0]   next_ptr, cur_desc;
  logic [1:0]      chan_state;
  logic [NSRC-1:0] pend, pick;
  logic [SW-1:0]   idx;

  xor_eng_regs #(.AW(AW)) u_regs (
    .clk_i, .rst_ni, .reg_we_i, .reg_addr_i, .reg_wdata_i,
    .chan_state_i(chan_state), .cur_desc_i(cur_desc), .reg_rdata_o,
    .mode_o(mode), .swap_o(swap), .next_ptr_o(next_ptr), .start_o(start)
  );

  xor_eng_srcsel #(.NSRC(NSRC)) u_sel (
    .pend_i(pend), .pick_o(pick), .idx_o(idx)
  );

  xor_eng_ctrl #(.AW(AW), .NSRC(NSRC), .MIN_BYTES(MIN_BYTES),
                 .MAX_BYTES(MAX_BYTES)) u_ctrl (
    .clk_i, .rst_ni, .start_i(start), .next_ptr_i(next_ptr),
    .mode_i(mode), .swap_i(swap), .pick_i(pick), .idx_i(idx),
    .pend_o(pend), .chan_state_o(chan_state), .cur_desc_o(cur_desc),
    .irq_o, .mem_req_o, .mem_we_o, .mem_addr_o, .mem_wdata_o,
    .mem_rdata_i, .mem_ack_i
  );
endmodule

// File: rtl/xor_desc_engine_chk.sv
module xor_desc_engine_chk
  import xor_eng_pkg::*;
#(
  parameter int AW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          reg_we_i,
  input logic [1:0]    reg_addr_i,
  input logic          act_bit,
  input logic          irq_o,
  input logic          mem_req_o,
  input logic          mem_we_o,
  input logic [AW-1:0] mem_addr_o,
  input logic [31:0]   mem_wdata_o,
  input logic          mem_ack_i,
  input logic [1:0]    chan_state,
  input logic [AW-1:0] cur_desc
);
  p_req_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o)
      && $stable(mem_we_o) && $stable(mem_wdata_o));

  p_quiet_unless_run_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chan_state != CH_RUN |-> !mem_req_o);

  p_state_legal_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chan_state != 2'd3);

  p_irq_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);

  p_irq_after_status_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(mem_req_o && mem_we_o && mem_ack_i));

  p_cur_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chan_state != CH_RUN) && !(reg_we_i && reg_addr_i == REG_ACT && act_bit)
      |=> $stable(cur_desc));
endmodule

bind xor_desc_engine xor_desc_engine_chk #(.AW(AW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i),
  .act_bit(reg_wdata_i[0]), .irq_o(irq_o), .mem_req_o(mem_req_o),
  .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
  .mem_ack_i(mem_ack_i), .chan_state(chan_state), .cur_desc(cur_desc)
);

// File: tb/xor_desc_engine_test.sv
`timescale 1ns/1ps
module xor_desc_engine_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq, mem_req, mem_we, ack;
  logic [31:0] mem_addr, mem_wdata, rdata;

  logic [31:0] mem [0:1023];
  int rd_cnt [8];
  int irq_cnt = 0;
  int viol = 0;
  logic wait_q;
  logic [31:0] wait_addr;
  logic tb_we = 1'b0;
  logic [31:0] tb_a = '0, tb_d = '0;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  xor_desc_engine uut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .irq_o(irq),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(rdata), .mem_ack_i(ack)
  );

  // memory model: ack one cycle after a request, data with ack
  always @(posedge clk) begin
    if (tb_we) mem[tb_a[11:2]] <= tb_d;
    if (!rst_n) begin
      ack <= 1'b0;
      wait_q <= 1'b0;
      wait_addr <= '0;
    end else begin
      ack <= mem_req && !ack;
      if (mem_req && !ack) begin
        if (mem_we) mem[mem_addr[11:2]] <= mem_wdata;
        else begin
          rdata <= mem[mem_addr[11:2]];
          if (mem_addr >= 32'h400 && mem_addr < 32'h600)
            rd_cnt[(mem_addr - 32'h400) >> 6] <= rd_cnt[(mem_addr - 32'h400) >> 6] + 1;
        end
      end
      if (irq) irq_cnt <= irq_cnt + 1;
      if (wait_q && (!mem_req || mem_addr != wait_addr)) viol <= viol + 1;
      wait_q <= mem_req && !ack;
      wait_addr <= mem_addr;
    end
  end

  function automatic logic [31:0] srcval(int i, int w);
    return {8'(8'h11 * i + w), 8'(i ^ (w << 3)), 8'(8'hA5 ^ i), 8'(w * 7 + i + 1)};
  endfunction

  function automatic logic [31:0] expx(logic [7:0] m, int w);
    logic [31:0] x = '0;
    for (int i = 0; i < 8; i++) if (m[i]) x ^= srcval(i, w);
    return x;
  endfunction

  function automatic logic [31:0] bsw(logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string tag);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic mw(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    tb_we = 1'b1; tb_a = a; tb_d = d;
    @(negedge clk);
    tb_we = 1'b0;
  endtask

  task automatic reg_wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic put_desc(input logic [31:0] a, input logic [31:0] cmd,
                          input logic [31:0] cnt, input logic [31:0] dst,
                          input logic [31:0] nxt, input bit sw);
    logic [31:0] w [13];
    w[0] = 32'h8000_0000; w[1] = cmd; w[2] = cnt; w[3] = dst; w[4] = nxt;
    for (int i = 0; i < 8; i++) w[5+i] = 32'h400 + 32'(i) * 32'h40;
    for (int k = 0; k < 13; k++) mw(a + 32'(k) * 4, sw ? bsw(w[k]) : w[k]);
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    int n = 0;
    do begin
      reg_rd(2'd2, v);
      n++;
    end while (v[5:4] == 2'd1 && n < 20000);
    if (n >= 20000) chk(32'd0, 32'd1, "R8 channel never left running state");
  endtask

  task automatic go(input logic [31:0] a);
    reg_wr(2'd1, a);
    reg_wr(2'd2, 32'd1);
    wait_idle();
  endtask

  initial begin
    #(150000 * 4);
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors + 1);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int base_rd [8];
    int base_irq, tot, dis;
    logic [7:0] m;

    repeat (3) @(negedge clk);
    chk({31'd0, mem_req}, 32'd0, "R1 no request in reset");
    rst_n = 1'b1;
    reg_rd(2'd2, v);
    chk({30'd0, v[5:4]}, 32'd0, "R1 state after reset");
    reg_rd(2'd3, v);
    chk(v, 32'd0, "R1 current descriptor after reset");
    chk({30'd0, irq, mem_req}, 32'd0, "R1 irq and request low");

    for (int i = 0; i < 8; i++)
      for (int w = 0; w < 16; w++)
        mw(32'h400 + 32'(i) * 32'h40 + 32'(w) * 4, srcval(i, w));

    // every source mask, XOR mode, 8 bytes
    for (int mi = 0; mi < 256; mi++) begin
      m = 8'(mi);
      for (int i = 0; i < 8; i++) base_rd[i] = rd_cnt[i];
      base_irq = irq_cnt;
      mw(32'h800, 32'hDEAD_BEEF);
      mw(32'h804, 32'hDEAD_BEEF);
      put_desc(32'h100, {m[0], 23'd0, m}, 32'd8, 32'h800, 32'd0, 1'b0);
      go(32'h100);
      chk(mem[32'h800 >> 2], expx(m, 0), $sformatf("R2 word0 mask %02h", m));
      chk(mem[32'h804 >> 2], expx(m, 1), $sformatf("R2 word1 mask %02h", m));
      tot = 0; dis = 0;
      for (int i = 0; i < 8; i++) begin
        tot += rd_cnt[i] - base_rd[i];
        if (!m[i]) dis += rd_cnt[i] - base_rd[i];
      end
      chk(32'(tot), 32'(2 * $countones(m)), $sformatf("R2 source reads mask %02h", m));
      chk(32'(dis), 32'd0, $sformatf("R2 disabled source read mask %02h", m));
      chk(mem[32'h100 >> 2], 32'h4000_0000, "R5 status write-back");
      reg_rd(2'd3, v);
      chk(v, 32'h100, "R5 current descriptor");
      chk(32'(irq_cnt - base_irq), 32'(m[0]), $sformatf("R6 irq count mask %02h", m));
      reg_rd(2'd2, v);
      chk({30'd0, v[5:4]}, 32'd0, "R11 idle after chain end");
    end

    // copy mode ignores the mask beyond slot 0
    reg_wr(2'd0, 32'h2);
    for (int i = 0; i < 8; i++) base_rd[i] = rd_cnt[i];
    put_desc(32'h100, 32'h0000_00F0, 32'd8, 32'h800, 32'd0, 1'b0);
    go(32'h100);
    chk(mem[32'h800 >> 2], srcval(0, 0), "R3 copy word0");
    chk(mem[32'h804 >> 2], srcval(0, 1), "R3 copy word1");
    chk(32'(rd_cnt[0] - base_rd[0]), 32'd2, "R3 slot0 reads");
    tot = 0;
    for (int i = 1; i < 8; i++) tot += rd_cnt[i] - base_rd[i];
    chk(32'(tot), 32'd0, "R3 other slots unread");
    reg_wr(2'd0, 32'h0);

    // three-descriptor chain
    base_irq = irq_cnt;
    put_desc(32'h100, 32'h8000_0003, 32'd8, 32'h800, 32'h140, 1'b0);
    put_desc(32'h140, 32'h0000_0081, 32'd8, 32'h840, 32'h180, 1'b0);
    put_desc(32'h180, 32'h8000_0000, 32'd8, 32'h880, 32'd0, 1'b0);
    mw(32'h884, 32'h1234_5678);
    go(32'h100);
    chk(mem[32'h804 >> 2], expx(8'h03, 1), "R4 chain first dest");
    chk(mem[32'h840 >> 2], expx(8'h81, 0), "R4 chain second dest");
    chk(mem[32'h884 >> 2], 32'd0, "R4 chain third dest empty mask");
    chk(mem[32'h180 >> 2], 32'h4000_0000, "R4 chain last status");
    reg_rd(2'd3, v);
    chk(v, 32'h180, "R5 current after chain");
    chk(32'(irq_cnt - base_irq), 32'd2, "R6 chain irq count");

    // bad byte counts mid-chain
    for (int b = 0; b < 3; b++) begin
      logic [31:0] bc;
      bc = (b == 0) ? 32'd6 : (b == 1) ? 32'd4 : 32'd1028;
      put_desc(32'h100, 32'h0000_0001, 32'd8, 32'h800, 32'h140, 1'b0);
      put_desc(32'h140, 32'h8000_0001, bc, 32'h840, 32'h180, 1'b0);
      put_desc(32'h180, 32'h0000_0002, 32'd8, 32'h880, 32'd0, 1'b0);
      mw(32'h840, 32'h5555_5555);
      base_irq = irq_cnt;
      go(32'h100);
      chk(mem[32'h100 >> 2], 32'h4000_0000, $sformatf("R7 prior ok count %0d", bc));
      chk(mem[32'h140 >> 2], 32'h0000_0001, $sformatf("R7 error status count %0d", bc));
      chk(mem[32'h840 >> 2], 32'h5555_5555, $sformatf("R7 no dest write count %0d", bc));
      chk(mem[32'h180 >> 2], 32'h8000_0000, $sformatf("R7 chain stopped count %0d", bc));
      reg_rd(2'd2, v);
      chk({30'd0, v[5:4]}, 32'd2, "R11 halted state");
      reg_rd(2'd3, v);
      chk(v, 32'h140, "R7 current at faulty descriptor");
      chk(32'(irq_cnt - base_irq), 32'd0, "R7 no irq on error");
      go(32'h180);
      chk(mem[32'h180 >> 2], 32'h4000_0000, "R8 restart after halt");
      reg_rd(2'd2, v);
      chk({30'd0, v[5:4]}, 32'd0, "R11 idle after restart");
    end

    // activation while running is ignored
    put_desc(32'h100, 32'h0000_00FF, 32'd64, 32'h900, 32'd0, 1'b0);
    put_desc(32'h140, 32'h0000_0005, 32'd8, 32'h880, 32'd0, 1'b0);
    reg_wr(2'd1, 32'h100);
    reg_wr(2'd2, 32'd1);
    reg_wr(2'd1, 32'h140);
    reg_wr(2'd2, 32'd1);
    wait_idle();
    chk(mem[32'h140 >> 2], 32'h8000_0000, "R8 second activation ignored");
    reg_rd(2'd3, v);
    chk(v, 32'h100, "R8 current stays on first");
    tot = 0;
    for (int w = 0; w < 16; w++) if (mem[(32'h900 >> 2) + w] !== expx(8'hFF, w)) tot++;
    chk(32'(tot), 32'd0, "R2 long transfer mismatching words");
    reg_wr(2'd2, 32'd1);
    wait_idle();
    chk(mem[32'h140 >> 2], 32'h4000_0000, "R8 idle activation runs next pointer");
    chk(mem[32'h884 >> 2], expx(8'h05, 1), "R8 appended descriptor data");

    // byte-reversed descriptors
    reg_wr(2'd0, 32'h8);
    put_desc(32'h100, 32'h0000_000F, 32'd8, 32'h800, 32'd0, 1'b1);
    go(32'h100);
    chk(mem[32'h800 >> 2], expx(8'h0F, 0), "R9 swapped descriptor word0");
    chk(mem[32'h804 >> 2], expx(8'h0F, 1), "R9 swapped descriptor word1");
    chk(mem[32'h100 >> 2], 32'h0000_0040, "R9 status reversed");
    reg_wr(2'd0, 32'h0);

    chk(32'(viol), 32'd0, "R10 request changed before ack");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule